// File: doc/BRIEF.md
# Compare-Top 8-bit PWM Timer

An 8-bit up-counter driven through a power-of-two prescaler, with three compare registers. Compare registers A and B each drive one output pin. Compare register C sets the period: when the restart mode is on, or when either channel runs as a PWM generator, the counter returns to zero on the tick after it has sat at C. The counter then runs from 0 to C, which makes the period C+1 ticks.

Software sees eight byte-wide registers through a simple write-strobe port with a combinational read path. Status bits are cleared by writing a one to them or by the matching acknowledge input. Each output channel can be disconnected, or can toggle, clear or set on a match. A channel can also run as a PWM output, which is set when the counter restarts and cleared on its compare match. A force strobe applies a channel's action at once without raising any status bit. A prescaler restart strobe realigns the tick timing.

Register map by address: 0 output control, 1 count control, 2 counter, 3 compare A, 4 compare B, 5 compare C (period top), 6 interrupt enables, 7 status.

Top module: `pwm_timer8`

## Requirements
- R1: After reset all eight registers read zero, both pin enables are low, and all three interrupt outputs are low.
- R2: Count control bits [3:0] select the tick rate. 0 stops the counter. A value n from 1 to 15 advances the counter once every 2^(n-1) clocks. After a prescaler restart, the first tick comes 2^(n-1) clocks later.
- R3: Writing one to count control bit 4 clears the prescaler. This bit always reads as zero.
- R4: With count control bit 5 set, a tick that finds the counter equal to compare C loads zero. With the bit clear and both PWM bits clear, the counter passes C and wraps from 0xFF to 0.
- R5: Status bit 0 (overflow) is set by a tick that finds the counter at 0xFF.
- R6: Status bits 1 and 2 are set by a tick that finds the counter equal to compare A or compare B. A status bit clears on a write of one or on its acknowledge input. A new event in the same cycle as a clear keeps the bit set.
- R7: Each interrupt output is high exactly when its status bit and its enable bit are both set. Enable bits 0, 1 and 2 map to overflow, A and B.
- R8: Output control bits [1:0] (channel A) and [3:2] (channel B) select the action on a match: 00 none/disconnected, 01 toggle, 10 clear, 11 set.
- R9: Output control bit 4 (A) or bit 5 (B) selects PWM mode for that channel and also enables the restart at compare C. In PWM mode the output is set on the restart tick and cleared on the channel's match tick. When both fall on the same tick, the set wins.
- R10: Output control bit 6 (A) or bit 7 (B) forces that channel's action, using the mode bits written in the same write. It sets no status bit and has no effect when the same write selects PWM mode. It reads as zero. If a force coincides with a match, the force decides the pin level and the match still sets its status bit.
- R11: A pin enable is high only when its direction input is high and its mode bits are not 00.
- R12: A write to the counter register takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| dir_a | input | 1 | Pin A direction, 1 = output |
| dir_b | input | 1 | Pin B direction, 1 = output |
| ack_ovf | input | 1 | Acknowledge, clears overflow status |
| ack_cmpa | input | 1 | Acknowledge, clears compare A status |
| ack_cmpb | input | 1 | Acknowledge, clears compare B status |
| pin_a | output | 1 | Channel A output level |
| pin_b | output | 1 | Channel B output level |
| pin_a_oe | output | 1 | Channel A drives its pin |
| pin_b_oe | output | 1 | Channel B drives its pin |
| irq_ovf | output | 1 | Overflow interrupt |
| irq_cmpa | output | 1 | Compare A interrupt |
| irq_cmpb | output | 1 | Compare B interrupt |

## Verification
Two cases can fall in the same cycle.

- **Force strobe and compare match.** The counter is preloaded to compare A while stopped. The tick rate is then started, and the very next write forces a level that differs from the one the old mode would give. The test passes when the pin shows the forced level and the compare A status bit is also set.
- **Status clear and compare event.** A write-one clear is placed on the match cycle, and the status bit must stay set.

Also checked in the same-cycle style: a counter write against a running tick, and a PWM restart against a channel match.

// File: rtl/pwm_timer8.sv
module pwm_timer8 #(
  parameter int PRE_W = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       dir_a,
  input  logic       dir_b,
  input  logic       ack_ovf,
  input  logic       ack_cmpa,
  input  logic       ack_cmpb,
  output logic       pin_a,
  output logic       pin_b,
  output logic       pin_a_oe,
  output logic       pin_b_oe,
  output logic       irq_ovf,
  output logic       irq_cmpa,
  output logic       irq_cmpb
);
  logic [1:0] mode_a, mode_b;
  logic       pwm_a, pwm_b, ctc;
  logic [3:0] sel;
  logic [7:0] count, cmp_a, cmp_b, cmp_c;
  logic [2:0] irq_en, flags;
  logic       oc_a, oc_b;
  logic [PRE_W-1:0] presc, mask;

  wire wr_ctla = reg_wr && reg_addr == 3'd0;
  wire wr_ctlb = reg_wr && reg_addr == 3'd1;
  wire wr_cnt  = reg_wr && reg_addr == 3'd2;
  wire wr_flg  = reg_wr && reg_addr == 3'd7;

  assign mask = (sel == 4'd0) ? '0 : ((PRE_W'(1) << (sel - 4'd1)) - PRE_W'(1));
  wire tick         = (sel != 4'd0) && ((presc & mask) == mask);
  wire restart_mode = ctc | pwm_a | pwm_b;
  wire hit_c   = tick && restart_mode && count == cmp_c;
  wire hit_a   = tick && count == cmp_a;
  wire hit_b   = tick && count == cmp_b;
  wire ovf_ev  = tick && count == 8'hFF;
  wire force_a = wr_ctla && reg_wdata[6] && !reg_wdata[4];
  wire force_b = wr_ctla && reg_wdata[7] && !reg_wdata[5];

  wire [2:0] ev  = {hit_b, hit_a, ovf_ev};
  wire [2:0] clr = ({3{wr_flg}} & reg_wdata[2:0]) | {ack_cmpb, ack_cmpa, ack_ovf};

  function automatic logic act(input logic [1:0] m, input logic cur);
    case (m)
      2'b01:   act = ~cur;
      2'b10:   act = 1'b0;
      2'b11:   act = 1'b1;
      default: act = cur;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_a <= '0; mode_b <= '0; pwm_a <= 1'b0; pwm_b <= 1'b0;
      sel <= '0; ctc <= 1'b0; count <= '0;
      cmp_a <= '0; cmp_b <= '0; cmp_c <= '0;
      irq_en <= '0; flags <= '0; presc <= '0;
      oc_a <= 1'b0; oc_b <= 1'b0;
    end else begin
      if (wr_ctla) begin
        mode_a <= reg_wdata[1:0]; mode_b <= reg_wdata[3:2];
        pwm_a <= reg_wdata[4]; pwm_b <= reg_wdata[5];
      end
      if (wr_ctlb) begin
        sel <= reg_wdata[3:0]; ctc <= reg_wdata[5];
      end
      if (reg_wr && reg_addr == 3'd3) cmp_a <= reg_wdata;
      if (reg_wr && reg_addr == 3'd4) cmp_b <= reg_wdata;
      if (reg_wr && reg_addr == 3'd5) cmp_c <= reg_wdata;
      if (reg_wr && reg_addr == 3'd6) irq_en <= reg_wdata[2:0];

      if (wr_ctlb && reg_wdata[4]) presc <= '0;
      else if (sel != 4'd0)        presc <= presc + PRE_W'(1);

      if (wr_cnt)     count <= reg_wdata;
      else if (tick)  count <= hit_c ? 8'd0 : count + 8'd1;

      flags <= (flags & ~clr) | ev;

      if (force_a)    oc_a <= act(reg_wdata[1:0], oc_a);
      else if (pwm_a) begin
        if (hit_c)      oc_a <= 1'b1;
        else if (hit_a) oc_a <= 1'b0;
      end else if (hit_a) oc_a <= act(mode_a, oc_a);

      if (force_b)    oc_b <= act(reg_wdata[3:2], oc_b);
      else if (pwm_b) begin
        if (hit_c)      oc_b <= 1'b1;
        else if (hit_b) oc_b <= 1'b0;
      end else if (hit_b) oc_b <= act(mode_b, oc_b);
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {2'b00, pwm_b, pwm_a, mode_b, mode_a};
      3'd1:    reg_rdata = {2'b00, ctc, 1'b0, sel};
      3'd2:    reg_rdata = count;
      3'd3:    reg_rdata = cmp_a;
      3'd4:    reg_rdata = cmp_b;
      3'd5:    reg_rdata = cmp_c;
      3'd6:    reg_rdata = {5'b0, irq_en};
      default: reg_rdata = {5'b0, flags};
    endcase
  end

  assign pin_a    = oc_a;
  assign pin_b    = oc_b;
  assign pin_a_oe = dir_a && mode_a != 2'b00;
  assign pin_b_oe = dir_b && mode_b != 2'b00;
  assign irq_ovf  = flags[0] & irq_en[0];
  assign irq_cmpa = flags[1] & irq_en[1];
  assign irq_cmpb = flags[2] & irq_en[2];
endmodule

// File: rtl/pwm_timer8_chk.sv
module pwm_timer8_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [2:0] reg_addr,
  input logic [7:0] reg_rdata,
  input logic       tick,
  input logic       restart_mode,
  input logic [3:0] sel,
  input logic [7:0] count,
  input logic [7:0] cmp_a,
  input logic [7:0] cmp_c,
  input logic [2:0] flags,
  input logic       dir_a,
  input logic       pin_a_oe,
  input logic       irq_cmpa
);
  wire wr_cnt = reg_wr && reg_addr == 3'd2;

  a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
    tick && restart_mode && count == cmp_c && !wr_cnt |=> count == 8'd0);

  a_r4_pass_top: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !restart_mode && !wr_cnt |=> count == 8'($past(count) + 8'd1));

  a_r2_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    sel == 4'd0 && !wr_cnt |=> $stable(count));

  a_r6_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    tick && count == cmp_a |=> flags[1]);

  a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq_cmpa |-> flags[1]);

  a_r10_force_reads0: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == 3'd0 |-> reg_rdata[7:6] == 2'b00);

  a_r11_no_dir: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_a |-> !pin_a_oe);
endmodule

bind pwm_timer8 pwm_timer8_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .tick(tick), .restart_mode(restart_mode),
  .sel(sel), .count(count), .cmp_a(cmp_a), .cmp_c(cmp_c), .flags(flags),
  .dir_a(dir_a), .pin_a_oe(pin_a_oe), .irq_cmpa(irq_cmpa)
);

// File: tb/tb_pwm_timer8.sv
module tb_pwm_timer8;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       dir_a = 1'b0, dir_b = 1'b0;
  logic       ack_ovf = 1'b0, ack_cmpa = 1'b0, ack_cmpb = 1'b0;
  logic       pin_a, pin_b, pin_a_oe, pin_b_oe, irq_ovf, irq_cmpa, irq_cmpb;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  pwm_timer8 dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dir_a(dir_a), .dir_b(dir_b),
    .ack_ovf(ack_ovf), .ack_cmpa(ack_cmpa), .ack_cmpb(ack_cmpb),
    .pin_a(pin_a), .pin_b(pin_b), .pin_a_oe(pin_a_oe), .pin_b_oe(pin_b_oe),
    .irq_ovf(irq_ovf), .irq_cmpa(irq_cmpa), .irq_cmpb(irq_cmpb)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      chk("R1 register reset", d, 0);
    end
    chk("R1 pin enables", {pin_a_oe, pin_b_oe}, 0);
    chk("R1 irqs", {irq_ovf, irq_cmpa, irq_cmpb}, 0);
  endtask

  task automatic t_restart();
    logic [7:0] prev, now, top;
    top = 0;
    wr(3'd5, 8'd5); wr(3'd2, 8'd0); wr(3'd1, 8'h21);
    rd(3'd2, prev);
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      rd(3'd2, now);
      chk("R4 restart sequence", now, (prev == 8'd5) ? 0 : prev + 1);
      if (now > top) top = now;
      prev = now;
    end
    chk("R4 top reached", top, 5);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_free();
    logic [7:0] d;
    wr(3'd7, 8'h07); wr(3'd2, 8'd4); wr(3'd1, 8'h01);
    repeat (3) @(negedge clk);
    rd(3'd2, d); chk("R4 passes compare C", d, 7);
    wr(3'd1, 8'h00); wr(3'd2, 8'hFD);
    rd(3'd7, d); chk("R5 no overflow yet", d[0], 0);
    wr(3'd1, 8'h01);
    repeat (2) @(negedge clk);
    rd(3'd2, d); chk("R5 count at FF", d, 8'hFF);
    rd(3'd7, d); chk("R5 flag before wrap", d[0], 0);
    @(negedge clk);
    rd(3'd2, d); chk("R4 wrap to zero", d, 0);
    rd(3'd7, d); chk("R5 overflow flag", d[0], 1);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_presc();
    logic [7:0] d;
    wr(3'd2, 8'd0); wr(3'd1, 8'h13);
    rd(3'd1, d); chk("R3 restart bit reads zero", d, 8'h03);
    repeat (3) @(negedge clk);
    rd(3'd2, d); chk("R2 div4 before first tick", d, 0);
    @(negedge clk);
    rd(3'd2, d); chk("R2 div4 first tick", d, 1);
    repeat (12) @(negedge clk);
    rd(3'd2, d); chk("R2 div4 after 16 clocks", d, 4);
    wr(3'd1, 8'h00);
    repeat (10) @(negedge clk);
    rd(3'd2, d); chk("R2 select 0 stops", d, 4);
  endtask

  task automatic t_flags();
    logic [7:0] d;
    wr(3'd7, 8'h07); wr(3'd3, 8'd3); wr(3'd6, 8'h02); wr(3'd2, 8'd0); wr(3'd1, 8'h01);
    repeat (3) @(negedge clk);
    rd(3'd7, d); chk("R6 no match yet", d[1], 0);
    @(negedge clk);
    rd(3'd7, d); chk("R6 compare A flag", d[1], 1);
    chk("R7 irq A enabled", irq_cmpa, 1);
    wr(3'd1, 8'h00); wr(3'd6, 8'h00);
    chk("R7 irq A masked", irq_cmpa, 0);
    ack_cmpa = 1'b1; @(negedge clk); ack_cmpa = 1'b0;
    rd(3'd7, d); chk("R6 ack clears", d[1], 0);
    wr(3'd2, 8'd3); wr(3'd1, 8'h01); wr(3'd7, 8'h02); wr(3'd1, 8'h00);
    rd(3'd7, d); chk("R6 set beats clear", d[1], 1);
    wr(3'd7, 8'h02);
    rd(3'd7, d); chk("R6 write-one clears", d[1], 0);
  endtask

  task automatic t_force();
    logic [7:0] d;
    wr(3'd7, 8'h07); dir_a = 1'b1;
    wr(3'd0, 8'h43); chk("R10 force set", pin_a, 1);
    chk("R11 enable with dir and mode", pin_a_oe, 1);
    wr(3'd0, 8'h42); chk("R10 force clear", pin_a, 0);
    wr(3'd0, 8'h41); chk("R8 force toggle up", pin_a, 1);
    wr(3'd0, 8'h41); chk("R8 force toggle down", pin_a, 0);
    rd(3'd7, d); chk("R10 force sets no flag", d, 0);
    rd(3'd0, d); chk("R10 force reads zero", d, 8'h01);
    dir_a = 1'b0; #1;
    chk("R11 no drive without dir", pin_a_oe, 0);
    dir_a = 1'b1;
    wr(3'd0, 8'h00); chk("R11 disconnected mode", pin_a_oe, 0);
    dir_b = 1'b1;
    wr(3'd0, 8'h8C); chk("R10 force set B", pin_b, 1);
    chk("R11 enable B", pin_b_oe, 1);
  endtask

  task automatic t_toggle();
    wr(3'd7, 8'h07); wr(3'd5, 8'd7); wr(3'd3, 8'd2); wr(3'd0, 8'h01);
    wr(3'd2, 8'd0); wr(3'd1, 8'h21);
    repeat (2) @(negedge clk); chk("R8 before match", pin_a, 0);
    @(negedge clk);            chk("R8 toggle on match", pin_a, 1);
    repeat (7) @(negedge clk); chk("R8 hold between matches", pin_a, 1);
    @(negedge clk);            chk("R8 second toggle", pin_a, 0);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_pwm();
    logic [7:0] d;
    wr(3'd0, 8'h12); wr(3'd3, 8'd3); wr(3'd5, 8'd9); wr(3'd2, 8'd0); wr(3'd1, 8'h01);
    repeat (12) @(negedge clk);
    for (int i = 0; i < 25; i++) begin
      rd(3'd2, d);
      chk("R9 pwm level vs count", pin_a, d <= 8'd3);
      chk("R9 count bounded by C", d <= 8'd9, 1);
      @(negedge clk);
    end
    wr(3'd3, 8'd9);
    repeat (12) @(negedge clk);
    for (int i = 0; i < 12; i++) begin
      chk("R9 restart wins over match", pin_a, 1);
      @(negedge clk);
    end
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h52); chk("R10 force ignored in pwm", pin_a, 1);
  endtask

  task automatic t_same_cycle();
    logic [7:0] d;
    wr(3'd1, 8'h00); wr(3'd0, 8'h43); wr(3'd7, 8'h07);
    wr(3'd3, 8'd10); wr(3'd2, 8'd10);
    wr(3'd1, 8'h01); wr(3'd0, 8'h42); wr(3'd1, 8'h00);
    chk("R10 force decides pin on match", pin_a, 0);
    rd(3'd7, d); chk("R10 match still flags", d[1], 1);
    wr(3'd1, 8'h01); wr(3'd2, 8'd50);
    rd(3'd2, d); chk("R12 write beats tick", d, 50);
    @(negedge clk);
    rd(3'd2, d); chk("R12 counts on from written", d, 51);
    wr(3'd1, 8'h00);
  endtask

  initial begin
    #3000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_restart();
    t_free();
    t_presc();
    t_flags();
    t_force();
    t_toggle();
    t_pwm();
    t_same_cycle();
    summary();
    $finish;
  end
endmodule